// File: doc/BRIEF.md
# Rotate Unit with Carry and Overflow Flags

This block rotates an operand left or right by a count and produces the matching carry and overflow bits of a status word. The operand may be a byte, a word or a doubleword. The unit takes one request per cycle on a valid strobe. One clock later it presents the rotated value and the updated status word, and it raises its output valid for that single cycle.

The count is reduced to the selected operand width before the rotation is applied. When the raw count is zero the status word passes through untouched. For any nonzero count, only the carry and overflow positions change, and their new values come from particular bits of the result. Every other status bit is copied across unchanged. Operand bits above the selected width are ignored, and the unit drives them to zero in the result.

Top module: `rot_flag_unit`

## Requirements
- R1: The rotate amount is the count modulo the operand width: count[2:0] for byte (width_sel=0), count[3:0] for word (width_sel=1), count[4:0] for doubleword (width_sel=2; the code 3 also selects doubleword).
- R2: With op_sel=0 the operand is rotated left: bits leaving the most significant end re-enter at bit 0.
- R3: With op_sel=1 the operand is rotated right: bits leaving bit 0 re-enter at the most significant bit of the selected width.
- R4: A raw count of zero returns the operand (masked to width) as the result, and the whole status word equals flags_in.
- R5: A nonzero count whose masked amount is zero leaves the data unrotated, but carry and overflow are still recomputed from that value.
- R6: For a left rotate with nonzero count, carry (flags bit 0) equals result bit 0, and overflow (flags bit 11) equals the result's top bit XOR result bit 0.
- R7: For a right rotate with nonzero count, carry (bit 0) equals the result's top bit, and overflow (bit 11) equals the XOR of the result's two top bits.
- R8: All status bits other than 0 and 11 are copied from flags_in for every request.
- R9: Operand bits above the selected width do not affect the outputs, and result bits above the width are zero.
- R10: Results appear in the cycle after in_valid. out_valid is high for exactly that one cycle per request, and result and flags_out hold their values while no request arrives.
- R11: While reset is asserted, out_valid, result and flags_out are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 1 | 0 rotate left, 1 rotate right |
| width_sel | input | 2 | 0 byte, 1 word, 2 or 3 doubleword |
| count | input | 8 | Raw rotate count |
| operand | input | 32 | Value to rotate |
| flags_in | input | 16 | Incoming status word |
| out_valid | output | 1 | One-cycle result strobe |
| result | output | 32 | Rotated value, zero above width |
| flags_out | output | 16 | Updated status word |

## Verification
Each output has one register between the request and the port, so result, flags_out and out_valid are all due at the first rising edge after the request cycle. The bench drives a request on a falling edge, withdraws it on the next falling edge, and samples all three outputs at that moment. A further falling-edge sample confirms that out_valid has dropped and that the data outputs are held.

// File: rtl/rot_pkg.sv
package rot_pkg;
  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } rot_dir_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2
  } rot_size_e;

  localparam int unsigned BASE_W = 8;
endpackage

// File: rtl/rot_lane.sv
module rot_lane #(
  parameter int unsigned LANE_W = 8,
  localparam int unsigned AMT_W = $clog2(LANE_W)
) (
  input  logic              dir_right,
  input  logic [AMT_W-1:0]  amt,
  input  logic [LANE_W-1:0] din,
  output logic [LANE_W-1:0] dout
);
  logic [2*LANE_W-1:0] dbl;
  logic [2*LANE_W-1:0] shl;
  logic [2*LANE_W-1:0] shr;

  always_comb begin
    dbl = {din, din};
    shl = dbl << amt;
    shr = dbl >> amt;
    if (dir_right) dout = shr[LANE_W-1:0];
    else           dout = shl[2*LANE_W-1:LANE_W];
  end
endmodule

// File: rtl/rot_flag_calc.sv
module rot_flag_calc #(
  parameter int unsigned NUM_SIZES = 3,
  parameter int unsigned FLAG_W    = 16,
  parameter int unsigned CF_POS    = 0,
  parameter int unsigned OF_POS    = 11,
  localparam int unsigned DATA_W   = rot_pkg::BASE_W << (NUM_SIZES - 1),
  localparam int unsigned SZ_W     = (NUM_SIZES > 1) ? $clog2(NUM_SIZES) : 1
) (
  input  logic [DATA_W-1:0] res,
  input  logic [SZ_W-1:0]   sz_idx,
  input  logic              dir_right,
  input  logic              count_nz,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [FLAG_W-1:0] flags_out
);
  logic [NUM_SIZES-1:0] top_bit;
  logic [NUM_SIZES-1:0] next_bit;

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_tap
    localparam int unsigned LW = rot_pkg::BASE_W << k;
    assign top_bit[k]  = res[LW-1];
    assign next_bit[k] = res[LW-2];
  end

  logic msb, msb_m1, cf_new, of_new;

  always_comb begin
    msb    = top_bit[sz_idx];
    msb_m1 = next_bit[sz_idx];
    if (dir_right) begin
      cf_new = msb;
      of_new = msb ^ msb_m1;
    end else begin
      cf_new = res[0];
      of_new = msb ^ res[0];
    end
    flags_out = flags_in;
    if (count_nz) begin
      flags_out[CF_POS] = cf_new;
      flags_out[OF_POS] = of_new;
    end
  end
endmodule

// File: rtl/rot_flag_unit.sv
module rot_flag_unit #(
  parameter int unsigned NUM_SIZES = 3,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned FLAG_W    = 16,
  parameter int unsigned CF_POS    = 0,
  parameter int unsigned OF_POS    = 11,
  localparam int unsigned DATA_W   = rot_pkg::BASE_W << (NUM_SIZES - 1),
  localparam int unsigned SZ_W     = (NUM_SIZES > 1) ? $clog2(NUM_SIZES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              op_sel,
  input  logic [1:0]        width_sel,
  input  logic [CNT_W-1:0]  count,
  input  logic [DATA_W-1:0] operand,
  input  logic [FLAG_W-1:0] flags_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags_out
);
  localparam logic [1:0] LAST_SZ = 2'(NUM_SIZES - 1);

  logic [SZ_W-1:0]   sz_idx;
  logic [DATA_W-1:0] lane_res [NUM_SIZES];
  logic [DATA_W-1:0] res_d;
  logic [FLAG_W-1:0] flags_d;
  logic              count_nz;

  always_comb begin
    if (width_sel > LAST_SZ) sz_idx = SZ_W'(LAST_SZ);
    else                     sz_idx = SZ_W'(width_sel);
  end

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_lane
    localparam int unsigned LW = rot_pkg::BASE_W << k;
    localparam int unsigned AW = $clog2(LW);
    logic [LW-1:0] lane_out;
    rot_lane #(.LANE_W(LW)) u_lane (
      .dir_right (op_sel),
      .amt       (count[AW-1:0]),
      .din       (operand[LW-1:0]),
      .dout      (lane_out)
    );
    assign lane_res[k] = DATA_W'(lane_out);
  end

  assign count_nz = |count;
  assign res_d    = lane_res[sz_idx];

  rot_flag_calc #(
    .NUM_SIZES (NUM_SIZES),
    .FLAG_W    (FLAG_W),
    .CF_POS    (CF_POS),
    .OF_POS    (OF_POS)
  ) u_flags (
    .res       (res_d),
    .sz_idx    (sz_idx),
    .dir_right (op_sel),
    .count_nz  (count_nz),
    .flags_in  (flags_in),
    .flags_out (flags_d)
  );

  // Reset synchronizer: asserts asynchronously, releases on a clock edge.
  logic rst_sync1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync1  <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_sync1  <= 1'b1;
      rst_sync_n <= rst_sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) out_valid <= 1'b0;
    else             out_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      result    <= '0;
      flags_out <= '0;
    end else if (in_valid) begin
      result    <= res_d;
      flags_out <= flags_d;
    end
  end
endmodule

// File: rtl/rot_flag_unit_chk.sv
module rot_flag_unit_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned FLAG_W = 16,
  parameter int unsigned CF_POS = 0,
  parameter int unsigned OF_POS = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              op_sel,
  input logic [1:0]        width_sel,
  input logic [CNT_W-1:0]  count,
  input logic [DATA_W-1:0] operand,
  input logic [FLAG_W-1:0] flags_in,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic [FLAG_W-1:0] flags_out
);
  logic [FLAG_W-1:0] keep_mask;
  logic [DATA_W-1:0] op_masked;
  always_comb begin
    keep_mask = '1;
    keep_mask[CF_POS] = 1'b0;
    keep_mask[OF_POS] = 1'b0;
    case (width_sel)
      2'd0:    op_masked = DATA_W'(operand[7:0]);
      2'd1:    op_masked = DATA_W'(operand[15:0]);
      default: op_masked = operand;
    endcase
  end

  AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R10
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R10
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(flags_out))); // R10
  AST_OTHER_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((flags_out & keep_mask) == ($past(flags_in) & keep_mask))); // R8
  AST_ZERO_COUNT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && count == '0) |=> (flags_out == $past(flags_in) && result == $past(op_masked))); // R4
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && width_sel == 2'd0) |=> (result[DATA_W-1:8] == '0)); // R9
  AST_LEFT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_sel && count != '0) |=> (flags_out[CF_POS] == result[0])); // R6
  AST_RIGHT_WORD_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel && width_sel == 2'd1 && count != '0)
      |=> (flags_out[OF_POS] == (result[15] ^ result[14]))); // R7
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && result == '0 && flags_out == '0)); // R11
endmodule

bind rot_flag_unit rot_flag_unit_chk #(
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W),
  .FLAG_W (FLAG_W),
  .CF_POS (CF_POS),
  .OF_POS (OF_POS)
) i_rot_flag_unit_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_sel    (op_sel),
  .width_sel (width_sel),
  .count     (count),
  .operand   (operand),
  .flags_in  (flags_in),
  .out_valid (out_valid),
  .result    (result),
  .flags_out (flags_out)
);

// File: tb/test_rot_flag_unit.sv
module test_rot_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        op_sel;
  logic [1:0]  width_sel;
  logic [7:0]  count;
  logic [31:0] operand;
  logic [15:0] flags_in;
  logic        out_valid;
  logic [31:0] result;
  logic [15:0] flags_out;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  rot_flag_unit i_rot_flag_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .width_sel(width_sel), .count(count), .operand(operand), .flags_in(flags_in),
    .out_valid(out_valid), .result(result), .flags_out(flags_out)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        op;
    logic [1:0]  wid;
    logic [7:0]  cnt;
    logic [31:0] a;
    logic [15:0] fin;
    logic [31:0] er;
    logic [15:0] ef;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'd6,  1'b0, 2'd0, 8'd1,   32'h0000_0081, 16'h0000, 32'h0000_0003, 16'h0801}, // R2 R6
    '{4'd7,  1'b1, 2'd0, 8'd1,   32'h0000_0001, 16'h0000, 32'h0000_0080, 16'h0801}, // R3 R7
    '{4'd8,  1'b0, 2'd1, 8'd4,   32'h0000_1234, 16'hF7FE, 32'h0000_2341, 16'hFFFF}, // R8 R2
    '{4'd7,  1'b1, 2'd1, 8'd4,   32'h0000_1234, 16'h08C5, 32'h0000_4123, 16'h08C4}, // R7 R3
    '{4'd2,  1'b0, 2'd2, 8'd8,   32'h8000_0001, 16'h0801, 32'h0000_0180, 16'h0000}, // R2
    '{4'd3,  1'b1, 2'd2, 8'd31,  32'h0000_0001, 16'h08D5, 32'h0000_0002, 16'h00D4}, // R3
    '{4'd4,  1'b0, 2'd0, 8'd0,   32'hFFFF_FF5A, 16'h0801, 32'h0000_005A, 16'h0801}, // R4
    '{4'd5,  1'b0, 2'd0, 8'd8,   32'h0000_0081, 16'h0000, 32'h0000_0081, 16'h0001}, // R5
    '{4'd5,  1'b1, 2'd1, 8'd16,  32'h0000_4000, 16'h0801, 32'h0000_4000, 16'h0800}, // R5
    '{4'd1,  1'b0, 2'd0, 8'd9,   32'h0000_0040, 16'h0000, 32'h0000_0080, 16'h0800}, // R1
    '{4'd1,  1'b0, 2'd3, 8'd33,  32'h8000_0000, 16'h0000, 32'h0000_0001, 16'h0801}, // R1
    '{4'd9,  1'b1, 2'd1, 8'd1,   32'hABCD_0003, 16'h0000, 32'h0000_8001, 16'h0801}, // R9
    '{4'd1,  1'b0, 2'd0, 8'hFF,  32'h0000_0002, 16'h0000, 32'h0000_0001, 16'h0801}  // R1
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic op, input logic [1:0] wid, input logic [7:0] cnt,
                       input logic [31:0] a, input logic [15:0] fin);
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; width_sel = wid; count = cnt; operand = a; flags_in = fin;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_sel = 1'b0; width_sel = 2'd0;
    count = 8'd0; operand = '0; flags_in = '0;
    repeat (3) @(negedge clk);
    // R11: outputs cleared during reset
    check("R11", "valid in reset", 32'(out_valid), 32'd0);
    check("R11", "result in reset", result, 32'd0);
    check("R11", "flags in reset", 32'(flags_out), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].op, VECS[i].wid, VECS[i].cnt, VECS[i].a, VECS[i].fin);
      check($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d result", i), result, VECS[i].er);
      check($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d flags", i), 32'(flags_out), 32'(VECS[i].ef));
      check("R10", $sformatf("vec %0d valid", i), 32'(out_valid), 32'd1);
    end

    // R10: valid drops after one cycle and outputs hold while idle
    operand = 32'hDEAD_BEEF; flags_in = 16'h1234; count = 8'd3;
    @(negedge clk);
    check("R10", "valid pulse ends", 32'(out_valid), 32'd0);
    check("R10", "result held", result, 32'h0000_0001);
    check("R10", "flags held", 32'(flags_out), 32'h0801);

    // R9: upper byte garbage with byte width, right rotate by 4
    issue(1'b1, 2'd0, 8'd4, 32'hFFFF_FF3C, 16'h0000);
    check("R9", "byte upper ignored", result, 32'h0000_00C3);
    check("R7", "byte right flags", 32'(flags_out), 32'h0001);

    // R11: reset in mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R11", "result after reset", result, 32'd0);
    check("R11", "flags after reset", 32'(flags_out), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule